// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block connects a simple 32-bit host bus to an 8-bit asynchronous NAND flash device. The host sees two word addresses. Address 0 is a control port. A write to it sets the latch mode, the chip enable and an outgoing data byte, and for the byte-carrying modes it produces one write strobe. A read of it returns the flash busy flag. Address 1 is a data port. Once read mode is armed, every host read of it fires one read strobe and returns the byte taken from the flash.

The host holds a request until the bridge answers with a one-cycle ready pulse. A strobed access holds the request for a setup cycle, then the strobe low time, then the recovery time. Accesses that need no strobe complete at once. The flash busy line is synchronised before it reaches the status word. Error correction is left to software. Only one 8-bit device is supported.

Word layout (bit 31 is most significant):
- bit 31 is chip enable.
- bits 30:28 are the latch mode.
- bits 23:16 are the data byte.
- bit 15 is busy.

Top module: `nand_host_bridge`

## Requirements
- R1: A control write with bits 30:28 equal to 0 (command), 1 (address) or 3 (data) gives exactly one write-strobe pulse. During that pulse bits 23:16 are driven on `flashIoOut`. Mode 0 sets `flashCmdLatch`=1 and `flashAddrLatch`=0. Mode 1 sets `flashAddrLatch`=1 and `flashCmdLatch`=0. Mode 3 holds both latch lines low.
- R2: Bit 31 of every control write, in any mode, sets the chip enable: `flashChipEnN` goes low when the bit is 1 and high when it is 0. The value holds until the next control write.
- R3: The write strobe stays low for exactly `LOW_CYC` cycles. `flashIoOe` is high for the whole time the strobe is low.
- R4: A control write with mode 2 gives no write strobe, holds both latch lines low and arms read mode. It completes one cycle after acceptance.
- R5: A data-port read with read mode armed gives one read-strobe pulse that is low for exactly `LOW_CYC` cycles. The flash byte is sampled on the edge that ends the low time. It is returned in bits 23:16, and every other bit is zero. `flashIoOe` stays low during the pulse.
- R6: A data-port read with read mode not armed gives no strobe and returns zero. A host write to the data port gives no strobe and changes neither the chip enable nor the latch lines.
- R7: A control-port read returns bit 15 = 1 while `flashBusyN` is low and 0 while it is high. All other bits are zero. The busy input passes through two flip-flops first.
- R8: A control write with a mode from 4 to 7 gives no strobe, holds both latch lines low and disarms read mode.
- R9: `hostReady` is a one-cycle pulse. A strobed access completes `LOW_CYC+HIGH_CYC+2` cycles after acceptance. A non-strobed access completes one cycle after acceptance.
- R10: After reset both strobes and the chip enable are inactive (high), the latch lines and `flashIoOe` are low, `hostReady` is low and read mode is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostReq | input | 1 | Access request, held until `hostReady` |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 1 | 0 = control port, 1 = data port |
| hostWdata | input | 32 | Write word |
| hostRdata | output | 32 | Read word, valid with `hostReady` |
| hostReady | output | 1 | Access complete, one cycle |
| flashChipEnN | output | 1 | Chip enable, active low |
| flashCmdLatch | output | 1 | Command latch enable |
| flashAddrLatch | output | 1 | Address latch enable |
| flashWrStrobeN | output | 1 | Write strobe, active low |
| flashRdStrobeN | output | 1 | Read strobe, active low |
| flashIoOut | output | 8 | Byte driven to flash I/O |
| flashIoOe | output | 1 | Output enable for `flashIoOut` |
| flashIoIn | input | 8 | Byte from flash I/O |
| flashBusyN | input | 1 | Ready/busy from flash, low = busy |

## Verification
- **Strobe width.** The bench counts every strobe edge and measures the width of each pulse. A design with an off-by-one cycle counter would show the wrong width and the wrong completion time.
- **Non-strobing writes.** It checks that mode 2, reserved modes and data-port writes give no strobe, yet still change the chip enable where they should. A design that decodes the mode loosely would strobe the flash with a stale byte.
- **Read capture.** It changes the flash byte between reads and checks the returned word layout. Sampling at the wrong edge, or putting the byte in the wrong lane, would return a stale or shifted value.
- **Busy status.** It reads the status after both levels of the busy line. A synchroniser with the wrong polarity would invert bit 15.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  localparam int CE_BIT   = 31;
  localparam int MODE_HI  = 30;
  localparam int MODE_LO  = 28;
  localparam int DATA_HI  = 23;
  localparam int DATA_LO  = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [2:0] MODE_CMD  = 3'd0;
  localparam logic [2:0] MODE_ADDR = 3'd1;
  localparam logic [2:0] MODE_READ = 3'd2;
  localparam logic [2:0] MODE_DATA = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCtrl;    // latch mode, chip enable, data byte
    logic loadStatus;  // load busy flag into read word
    logic clearRd;     // zero the read word
    logic capture;     // sample flash byte into read word
    logic weLow;       // write strobe active
    logic reLow;       // read strobe active
    logic driveIo;     // drive flash I/O
  } bridgeStrobe_t;

  function automatic logic modeStrobes(input logic [2:0] mode);
    return (mode == MODE_CMD) || (mode == MODE_ADDR) || (mode == MODE_DATA);
  endfunction

endpackage

// File: rtl/nand_bridge_ctrl.sv
module nand_bridge_ctrl
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic          hostWr,
  input  logic          hostAddr,
  input  logic [2:0]    wrMode,
  input  logic          readArmed,
  output bridgeStrobe_t strobe,
  output logic          hostReady
);

  localparam int MAX_CYC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

  busState_t     state;
  logic [CW-1:0] cnt;
  logic          isWrite;
  logic          ctrlRead;

  assign ctrlRead = !hostAddr && !hostWr;

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (hostReq) begin
          strobe.loadCtrl   = !hostAddr && hostWr;
          strobe.loadStatus = ctrlRead;
          strobe.clearRd    = !ctrlRead;
        end
      end
      ST_SETUP: strobe.driveIo = isWrite;
      ST_LOW: begin
        strobe.weLow   = isWrite;
        strobe.reLow   = !isWrite;
        strobe.driveIo = isWrite;
        strobe.capture = !isWrite && (cnt == LOW_LAST);
      end
      ST_HIGH: strobe.driveIo = isWrite;
      default: ;
    endcase
  end

  assign hostReady = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostReq) begin
            if (!hostAddr && hostWr && modeStrobes(wrMode)) begin
              state   <= ST_SETUP;
              isWrite <= 1'b1;
            end else if (hostAddr && !hostWr && readArmed) begin
              state   <= ST_SETUP;
              isWrite <= 1'b0;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_SETUP: begin
          state <= ST_LOW;
          cnt   <= '0;
        end
        ST_LOW: begin
          if (cnt == LOW_LAST) begin
            state <= ST_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt == HIGH_LAST) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_bridge_dp.sv
module nand_bridge_dp
  import nand_bridge_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  bridgeStrobe_t strobe,
  input  logic [31:0]   hostWdata,
  input  logic [7:0]    flashIoIn,
  input  logic          flashBusyN,
  output logic [31:0]   hostRdata,
  output logic          readArmed,
  output logic          flashChipEnN,
  output logic          flashCmdLatch,
  output logic          flashAddrLatch,
  output logic          flashWrStrobeN,
  output logic          flashRdStrobeN,
  output logic [7:0]    flashIoOut,
  output logic          flashIoOe
);

  logic [2:0]  modeQ;
  logic        ceQ;
  logic [7:0]  dataQ;
  logic [31:0] rdataQ;
  logic [1:0]  busySync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 3'd7;
      ceQ   <= 1'b0;
      dataQ <= '0;
    end else if (strobe.loadCtrl) begin
      modeQ <= hostWdata[MODE_HI:MODE_LO];
      ceQ   <= hostWdata[CE_BIT];
      dataQ <= hostWdata[DATA_HI:DATA_LO];
    end
  end

  // Two-flop synchroniser on the busy line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busySync <= 2'b11;
    else       busySync <= {busySync[0], flashBusyN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobe.loadStatus) begin
      rdataQ           <= '0;
      rdataQ[BUSY_BIT] <= !busySync[1];
    end else if (strobe.clearRd) begin
      rdataQ <= '0;
    end else if (strobe.capture) begin
      rdataQ[DATA_HI:DATA_LO] <= flashIoIn;
    end
  end

  assign hostRdata      = rdataQ;
  assign readArmed      = (modeQ == MODE_READ);
  assign flashChipEnN   = !ceQ;
  assign flashCmdLatch  = (modeQ == MODE_CMD);
  assign flashAddrLatch = (modeQ == MODE_ADDR);
  assign flashWrStrobeN = !strobe.weLow;
  assign flashRdStrobeN = !strobe.reLow;
  assign flashIoOut     = dataQ;
  assign flashIoOe      = strobe.driveIo;

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  logic        hostWr,
  input  logic        hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostReady,
  output logic        flashChipEnN,
  output logic        flashCmdLatch,
  output logic        flashAddrLatch,
  output logic        flashWrStrobeN,
  output logic        flashRdStrobeN,
  output logic [7:0]  flashIoOut,
  output logic        flashIoOe,
  input  logic [7:0]  flashIoIn,
  input  logic        flashBusyN
);

  bridgeStrobe_t strobe;
  logic          readArmed;

  nand_bridge_ctrl #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .wrMode    (hostWdata[MODE_HI:MODE_LO]),
    .readArmed (readArmed),
    .strobe    (strobe),
    .hostReady (hostReady)
  );

  nand_bridge_dp u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .hostWdata      (hostWdata),
    .flashIoIn      (flashIoIn),
    .flashBusyN     (flashBusyN),
    .hostRdata      (hostRdata),
    .readArmed      (readArmed),
    .flashChipEnN   (flashChipEnN),
    .flashCmdLatch  (flashCmdLatch),
    .flashAddrLatch (flashAddrLatch),
    .flashWrStrobeN (flashWrStrobeN),
    .flashRdStrobeN (flashRdStrobeN),
    .flashIoOut     (flashIoOut),
    .flashIoOe      (flashIoOe)
  );

endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk #(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostReq,
  input logic        hostWr,
  input logic        hostAddr,
  input logic [31:0] hostRdata,
  input logic        hostReady,
  input logic        flashCmdLatch,
  input logic        flashAddrLatch,
  input logic        flashWrStrobeN,
  input logic        flashRdStrobeN,
  input logic        flashIoOe
);

  logic [15:0] weRun;
  logic [15:0] reRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weRun <= '0;
      reRun <= '0;
    end else begin
      weRun <= flashWrStrobeN ? 16'd0 : ((weRun == 16'hFFFF) ? weRun : weRun + 16'd1);
      reRun <= flashRdStrobeN ? 16'd0 : ((reRun == 16'hFFFF) ? reRun : reRun + 16'd1);
    end
  end

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWrStrobeN) |-> (weRun == 16'(LOW_CYC))); // R3

  AST_RE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashRdStrobeN) |-> (reRun == 16'(LOW_CYC))); // R5

  AST_IO_DRIVEN_ON_WE: assert property (@(posedge clk) disable iff (!rstN)
    !flashWrStrobeN |-> flashIoOe); // R3

  AST_IO_FREE_ON_RE: assert property (@(posedge clk) disable iff (!rstN)
    !flashRdStrobeN |-> !flashIoOe); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWrStrobeN && !flashRdStrobeN)); // R1

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flashCmdLatch && flashAddrLatch)); // R1

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady); // R9

  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && hostReq && !hostWr && !hostAddr) |-> ((hostRdata & 32'hFFFF_7FFF) == 32'd0)); // R7

  AST_DATA_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (hostReady && hostReq && !hostWr && hostAddr) |-> ((hostRdata & 32'hFF00_FFFF) == 32'd0)); // R5

endmodule

bind nand_host_bridge nand_bridge_chk #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .hostReq        (hostReq),
  .hostWr         (hostWr),
  .hostAddr       (hostAddr),
  .hostRdata      (hostRdata),
  .hostReady      (hostReady),
  .flashCmdLatch  (flashCmdLatch),
  .flashAddrLatch (flashAddrLatch),
  .flashWrStrobeN (flashWrStrobeN),
  .flashRdStrobeN (flashRdStrobeN),
  .flashIoOe      (flashIoOe)
);

// File: tb/nand_host_bridge_tb.sv
module nand_host_bridge_tb;

  localparam int LOW_CYC  = 3;
  localparam int HIGH_CYC = 2;
  localparam int STROBED  = LOW_CYC + HIGH_CYC + 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostAddr = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostReady;
  logic        flashChipEnN, flashCmdLatch, flashAddrLatch;
  logic        flashWrStrobeN, flashRdStrobeN, flashIoOe;
  logic [7:0]  flashIoOut;
  logic [7:0]  flashIoIn = 8'h00;
  logic        flashBusyN = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  nand_host_bridge #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostReady(hostReady),
    .flashChipEnN(flashChipEnN), .flashCmdLatch(flashCmdLatch), .flashAddrLatch(flashAddrLatch),
    .flashWrStrobeN(flashWrStrobeN), .flashRdStrobeN(flashRdStrobeN), .flashIoOut(flashIoOut),
    .flashIoOe(flashIoOe), .flashIoIn(flashIoIn), .flashBusyN(flashBusyN)
  );

  // Strobe monitor, sampled at the falling clock edge
  int       weFalls = 0, reFalls = 0, weWidth = 0, reWidth = 0, oeBad = 0, oeOnRead = 0;
  logic     prevWe = 1'b1, prevRe = 1'b1;
  logic [7:0] weByte = '0;
  logic     weCmd = 1'b0, weAddr = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!flashWrStrobeN) begin
        if (prevWe) begin
          weFalls++;
          weWidth = 0;
          weByte  = flashIoOut;
          weCmd   = flashCmdLatch;
          weAddr  = flashAddrLatch;
        end
        weWidth++;
        if (!flashIoOe) oeBad++;
      end
      if (!flashRdStrobeN) begin
        if (prevRe) begin
          reFalls++;
          reWidth = 0;
        end
        reWidth++;
        if (flashIoOe) oeOnRead++;
      end
    end
    prevWe = flashWrStrobeN;
    prevRe = flashRdStrobeN;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit addr, input logic [31:0] wdata,
                        output logic [31:0] rdata, output int cycles);
    @(negedge clk);
    hostReq   = 1'b1;
    hostWr    = wr;
    hostAddr  = addr;
    hostWdata = wdata;
    cycles    = 0;
    rdata     = '0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cycles++;
      if (hostReady) begin
        rdata = hostRdata;
        break;
      end
    end
    hostReq = 1'b0;
    hostWr  = 1'b0;
    if (!hostReady) check(1'b0, "R9 handshake timeout", cycles, 0);
    @(negedge clk);
    check(!hostReady, "R9 ready one cycle", hostReady, 0);
  endtask

  function automatic logic [31:0] ctrlWord(input bit ce, input logic [2:0] mode, input logic [7:0] b);
    return {ce, mode, 4'h0, b, 16'h0};
  endfunction

  task automatic t_reset();
    check(flashWrStrobeN && flashRdStrobeN, "R10 strobes idle", {flashWrStrobeN, flashRdStrobeN}, 2'b11);
    check(flashChipEnN, "R10 chip enable off", flashChipEnN, 1);
    check(!flashCmdLatch && !flashAddrLatch, "R10 latches low", {flashCmdLatch, flashAddrLatch}, 0);
    check(!flashIoOe && !hostReady, "R10 io and ready low", {flashIoOe, hostReady}, 0);
  endtask

  task automatic t_strobed_write(input logic [2:0] mode, input logic [7:0] b, input bit expCmd,
                                 input bit expAddr, input string tag);
    logic [31:0] rd;
    int cyc;
    int falls0 = weFalls;
    access(1'b1, 1'b0, ctrlWord(1'b1, mode, b), rd, cyc);
    check(weFalls == falls0 + 1, {tag, " R1 one write pulse"}, weFalls - falls0, 1);
    check(weByte == b, {tag, " R1 data byte"}, weByte, b);
    check(weCmd == expCmd && weAddr == expAddr, {tag, " R1 latch lines"}, {weCmd, weAddr}, {expCmd, expAddr});
    check(weWidth == LOW_CYC, {tag, " R3 low width"}, weWidth, LOW_CYC);
    check(oeBad == 0, {tag, " R3 io driven"}, oeBad, 0);
    check(cyc == STROBED, {tag, " R9 strobed latency"}, cyc, STROBED);
    check(!flashChipEnN, {tag, " R2 chip enable on"}, flashChipEnN, 0);
  endtask

  task automatic t_arm_read();
    logic [31:0] rd;
    int cyc;
    int falls0 = weFalls;
    access(1'b1, 1'b0, ctrlWord(1'b1, 3'd2, 8'hFF), rd, cyc);
    check(weFalls == falls0, "R4 no write pulse", weFalls - falls0, 0);
    check(!flashCmdLatch && !flashAddrLatch, "R4 latches low", {flashCmdLatch, flashAddrLatch}, 0);
    check(cyc == 1, "R4 immediate completion", cyc, 1);
    check(!flashChipEnN, "R2 chip enable kept in mode 2", flashChipEnN, 0);
  endtask

  task automatic t_data_read(input logic [7:0] b);
    logic [31:0] rd;
    int cyc;
    int falls0 = reFalls;
    flashIoIn = b;
    access(1'b0, 1'b1, 32'h0, rd, cyc);
    check(reFalls == falls0 + 1, "R5 one read pulse", reFalls - falls0, 1);
    check(reWidth == LOW_CYC, "R5 read low width", reWidth, LOW_CYC);
    check(rd == {8'h00, b, 16'h0000}, "R5 returned word", rd, {8'h00, b, 16'h0000});
    check(oeOnRead == 0, "R5 io released", oeOnRead, 0);
    check(cyc == STROBED, "R9 read latency", cyc, STROBED);
  endtask

  task automatic t_busy();
    logic [31:0] rd;
    int cyc;
    flashBusyN = 1'b0;
    repeat (4) @(negedge clk);
    access(1'b0, 1'b0, 32'h0, rd, cyc);
    check(rd == 32'h0000_8000, "R7 busy set", rd, 32'h0000_8000);
    check(cyc == 1, "R9 status latency", cyc, 1);
    flashBusyN = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 1'b0, 32'h0, rd, cyc);
    check(rd == 32'h0, "R7 busy clear", rd, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] rd;
    int cyc;
    int we0 = weFalls;
    int re0 = reFalls;
    access(1'b1, 1'b0, ctrlWord(1'b0, 3'd5, 8'h77), rd, cyc);
    check(weFalls == we0, "R8 no strobe", weFalls - we0, 0);
    check(!flashCmdLatch && !flashAddrLatch, "R8 latches low", {flashCmdLatch, flashAddrLatch}, 0);
    check(flashChipEnN, "R2 chip enable off by reserved write", flashChipEnN, 1);
    access(1'b0, 1'b1, 32'h0, rd, cyc);
    check(reFalls == re0 && rd == 32'h0, "R8 R6 read disarmed", rd, 0);
    check(cyc == 1, "R6 disarmed read latency", cyc, 1);
  endtask

  task automatic t_dataport_write();
    logic [31:0] rd;
    int cyc;
    int we0 = weFalls;
    int re0 = reFalls;
    access(1'b1, 1'b0, ctrlWord(1'b1, 3'd0, 8'h70), rd, cyc);
    access(1'b1, 1'b1, ctrlWord(1'b0, 3'd1, 8'h11), rd, cyc);
    check(weFalls == we0 + 1 && reFalls == re0, "R6 data write no strobe", weFalls - we0, 1);
    check(!flashChipEnN && flashCmdLatch && !flashAddrLatch, "R6 data write keeps state",
          {flashChipEnN, flashCmdLatch, flashAddrLatch}, 3'b010);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rstN = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_strobed_write(3'd0, 8'h90, 1'b1, 1'b0, "cmd");
        t_strobed_write(3'd1, 8'h5A, 1'b0, 1'b1, "addr");
        t_strobed_write(3'd3, 8'hC3, 1'b0, 1'b0, "data");
        t_arm_read();
        t_data_read(8'hA7);
        t_data_read(8'h3C);
        t_busy();
        t_reserved();
        t_dataport_write();
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule